// File: doc/BRIEF.md
# Sideband Interrupt Aggregator

This block gathers up to eighteen sideband interrupt request wires and folds them into a single active-high cascade request for a parent interrupt controller. Each wire is first passed through a two-flop synchroniser. It is then normalised by its own polarity bit and captured into a sticky pending bit. Capture follows one of two global rules: either the pending bit follows the active level, or it records only inactive-to-active transitions.

Software reaches the block over a simple word-wide register bus with an address, a write strobe, write data and combinational read data. The bus has no handshake and no back-pressure. A write is accepted on every rising edge where the write strobe is high. A read returns data in the same cycle the address is presented. There is no streaming data path, so every pin is a plain control or status signal. The cascade output is high while the global enable is set and at least one source is both pending and unmasked.

Register map (byte offsets):

- 0x00 is control. Bit 31 is the global enable and bit 30 selects edge capture.
- 0x04 is the mask register.
- 0x08 is pending, which is read-only.
- 0x0C is the write-one-to-clear port.
- 0x10 is polarity.

Top module: `sideband_irq_agg`

## Requirements
- R1: After reset, control, mask and pending read 0x00000000, polarity reads 0x0003FFFF (every source active high), and the cascade output is low.
- R2: Reads are combinational and return the register selected by the byte offsets 0x00, 0x04, 0x08, 0x0C and 0x10. Any other address reads zero. Bits 31:18 of mask, pending and polarity read zero. Control keeps only bit 31 (global enable) and bit 30 (edge mode), and every other control bit reads zero. The clear port reads zero.
- R3: Control, mask and polarity read back the value last written to them, within the widths stated in R2.
- R4: In level mode, a request that turns active is visible in pending after the third rising edge that follows the change, and not before.
- R5: A polarity bit of 1 makes its source active when the wire is high. A polarity bit of 0 makes it active when the wire is low.
- R6: In level mode (control bit 30 = 0), a pending bit whose source is still active stays set through a clear write.
- R7: In edge mode (control bit 30 = 1), a pending bit is set only on an inactive-to-active transition. Once cleared, it stays clear while the source is held active.
- R8: Writing 1 to a bit of the clear port (0x0C) clears that pending bit. Writing 0 leaves the bit unchanged. Writes to the pending offset (0x08) change nothing.
- R9: When a new capture and a clear write hit the same pending bit on the same edge, the bit ends up set.
- R10: The cascade output is high exactly when control bit 31 is 1 and some bit is 1 in both mask and pending. It follows pending and mask in the same cycle.
- R11: Pending bits capture regardless of the mask. A masked source is visible in pending, and it drives the cascade output as soon as it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 18 | Asynchronous interrupt request wires |
| bus_addr_i | input | 5 | Register byte address |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| cascade_irq_o | output | 1 | Summary request to the parent, active high |

## Verification
Each result has a fixed due time:

- Read data is due in the same cycle as the address.
- A register write or clear write takes effect at the rising edge that samples the strobe.
- A request wire change reaches pending after the third rising edge that follows it.
- The cascade output moves in the same cycle as pending or mask.

The bench drives every input 1 ns after a rising edge and samples 1 ns after driving. It advances a cycle-true reference model by exactly one edge per step. Directed latency checks count edges explicitly: zero after two edges, set after the third.

// File: rtl/sbirq_pkg.sv
`timescale 1ns/1ps
package sbirq_pkg;

  localparam logic [31:0] OFS_CTL = 32'h00;
  localparam logic [31:0] OFS_MSK = 32'h04;
  localparam logic [31:0] OFS_PND = 32'h08;
  localparam logic [31:0] OFS_CLR = 32'h0C;
  localparam logic [31:0] OFS_POL = 32'h10;

  typedef enum logic [2:0] {
    SEL_CTL,
    SEL_MSK,
    SEL_PND,
    SEL_CLR,
    SEL_POL,
    SEL_NONE
  } reg_sel_e;

  typedef struct packed {
    logic gen_en;
    logic edge_mode;
  } ctl_t;

  function automatic reg_sel_e decode_reg(input logic [31:0] byte_addr);
    reg_sel_e sel;
    case (byte_addr)
      OFS_CTL: sel = SEL_CTL;
      OFS_MSK: sel = SEL_MSK;
      OFS_PND: sel = SEL_PND;
      OFS_CLR: sel = SEL_CLR;
      OFS_POL: sel = SEL_POL;
      default: sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/sbirq_sync.sv
`timescale 1ns/1ps
module sbirq_sync #(
  parameter int WIDTH  = 18,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // R4: the first stage takes the raw wire one edge later
  assert_sync_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (stage_q[0] == $past(d_i)));

  generate
    for (genvar gk = 1; gk < STAGES; gk++) begin : g_shift_chk
      // R4: each later stage is a pure one-edge delay of the one before it
      assert_sync_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stage_q[gk] == $past(stage_q[gk-1]));
    end
  endgenerate

endmodule

// File: rtl/sbirq_capture.sv
`timescale 1ns/1ps
module sbirq_capture #(
  parameter int NUM_SRC = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic               edge_mode_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] act_w;
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] set_w;
  logic [NUM_SRC-1:0] pend_q;

  // Polarity 1: high is active. Polarity 0: low is active.
  assign act_w = ~(level_i ^ pol_i);

  always_comb begin
    if (edge_mode_i) set_w = act_w & ~prev_q;
    else             set_w = act_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= act_w;
      // A capture on the same edge overrides the clear.
      pend_q <= (pend_q & ~clr_i) | set_w;
    end
  end

  assign pend_o = pend_q;

  generate
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_bit_chk
      assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[gi] && !set_w[gi]) |=> !pend_q[gi]);
      assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_w[gi] |=> pend_q[gi]);
      assert_no_spurious_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pend_q[gi] && !set_w[gi]) |=> !pend_q[gi]);
      assert_edge_needs_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode_i && prev_q[gi] && !pend_q[gi]) |=> !pend_q[gi]);
    end
  endgenerate

endmodule

// File: rtl/sbirq_regs.sv
`timescale 1ns/1ps
module sbirq_regs
  import sbirq_pkg::*;
#(
  parameter int NUM_SRC = 18,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [DATA_W-1:0]  rdata_o,
  output ctl_t               ctl_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] pol_o,
  output logic [NUM_SRC-1:0] clr_o
);

  localparam int EN_BIT   = DATA_W - 1;
  localparam int EDGE_BIT = DATA_W - 2;

  reg_sel_e           sel_w;
  ctl_t               ctl_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pol_q;
  logic               unused_wdata_w;

  assign sel_w          = decode_reg(32'(addr_i));
  assign unused_wdata_w = ^wdata_i[EDGE_BIT-1:NUM_SRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      mask_q <= '0;
      pol_q  <= '1;
    end else if (we_i) begin
      case (sel_w)
        SEL_CTL: begin
          ctl_q.gen_en    <= wdata_i[EN_BIT];
          ctl_q.edge_mode <= wdata_i[EDGE_BIT];
        end
        SEL_MSK: mask_q <= wdata_i[NUM_SRC-1:0];
        SEL_POL: pol_q  <= wdata_i[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && sel_w == SEL_CLR) ? wdata_i[NUM_SRC-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (sel_w)
      SEL_CTL: begin
        rdata_o[EN_BIT]   = ctl_q.gen_en;
        rdata_o[EDGE_BIT] = ctl_q.edge_mode;
      end
      SEL_MSK: rdata_o[NUM_SRC-1:0] = mask_q;
      SEL_PND: rdata_o[NUM_SRC-1:0] = pend_i;
      SEL_POL: rdata_o[NUM_SRC-1:0] = pol_q;
      default: ;
    endcase
  end

  assign ctl_o  = ctl_q;
  assign mask_o = mask_q;
  assign pol_o  = pol_q;

  assert_mask_readback_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_w == SEL_MSK) |=> (mask_o == $past(wdata_i[NUM_SRC-1:0])));
  assert_pol_readback_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_w == SEL_POL) |=> (pol_o == $past(wdata_i[NUM_SRC-1:0])));
  assert_ctl_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_w == SEL_CTL) |=> $stable(ctl_o));

endmodule

// File: rtl/sideband_irq_agg.sv
`timescale 1ns/1ps
module sideband_irq_agg
  import sbirq_pkg::*;
#(
  parameter int NUM_SRC     = 18,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               cascade_irq_o
);

  ctl_t               ctl_w;
  logic [NUM_SRC-1:0] level_w;
  logic [NUM_SRC-1:0] mask_w;
  logic [NUM_SRC-1:0] pol_w;
  logic [NUM_SRC-1:0] clr_w;
  logic [NUM_SRC-1:0] pend_w;

  sbirq_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_req_i),
    .q_o    (level_w)
  );

  sbirq_capture #(
    .NUM_SRC (NUM_SRC)
  ) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_i     (level_w),
    .pol_i       (pol_w),
    .edge_mode_i (ctl_w.edge_mode),
    .clr_i       (clr_w),
    .pend_o      (pend_w)
  );

  sbirq_regs #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .we_i    (bus_we_i),
    .wdata_i (bus_wdata_i),
    .pend_i  (pend_w),
    .rdata_o (bus_rdata_o),
    .ctl_o   (ctl_w),
    .mask_o  (mask_w),
    .pol_o   (pol_w),
    .clr_o   (clr_w)
  );

  assign cascade_irq_o = ctl_w.gen_en & (|(mask_w & pend_w));

  // R10: without a bus write, pending bits can only be added, so the request holds
  assert_cascade_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cascade_irq_o && !bus_we_i) |=> cascade_irq_o);
  // R10: dropping the global enable silences the output on the next cycle
  assert_global_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && decode_reg(32'(bus_addr_i)) == SEL_CTL && !bus_wdata_i[DATA_W-1])
      |=> !cascade_irq_o);

endmodule

// File: tb/sideband_irq_agg_tb_top.sv
`timescale 1ns/1ps
module sideband_irq_agg_tb_top;

  localparam int N  = 18;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam logic [N-1:0] ALL = '1;

  localparam logic [AW-1:0] A_CTL = 5'h00;
  localparam logic [AW-1:0] A_MSK = 5'h04;
  localparam logic [AW-1:0] A_PND = 5'h08;
  localparam logic [AW-1:0] A_CLR = 5'h0C;
  localparam logic [AW-1:0] A_POL = 5'h10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          cascade;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference state
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_pend = '0, m_msk = '0, m_pol = '1;
  logic m_gen = 1'b0, m_edge = 1'b0;

  always #2.5 clk = ~clk;

  sideband_irq_agg dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .irq_req_i     (req),
    .bus_addr_i    (addr),
    .bus_we_i      (we),
    .bus_wdata_i   (wdata),
    .bus_rdata_o   (rdata),
    .cascade_irq_o (cascade)
  );

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = '0;
    case (a)
      A_CTL: begin v[31] = m_gen; v[30] = m_edge; end
      A_MSK: v[N-1:0] = m_msk;
      A_PND: v[N-1:0] = m_pend;
      A_POL: v[N-1:0] = m_pol;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic model_cascade();
    return m_gen & (|(m_msk & m_pend));
  endfunction

  task automatic step();
    logic [N-1:0] act, setv, clr;
    act  = ~(m_s2 ^ m_pol);
    setv = m_edge ? (act & ~m_prev) : act;
    clr  = (we && addr == A_CLR) ? wdata[N-1:0] : '0;
    @(posedge clk);
    #1;
    m_pend = (m_pend & ~clr) | setv;
    m_prev = act;
    m_s2   = m_s1;
    m_s1   = req;
    if (we) begin
      case (addr)
        A_CTL: begin m_gen = wdata[31]; m_edge = wdata[30]; end
        A_MSK: m_msk = wdata[N-1:0];
        A_POL: m_pol = wdata[N-1:0];
        default: ;
      endcase
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    addr = a; we = 1'b0;
    #1;
    v = rdata;
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic chk_model(input string tag);
    logic [DW-1:0] v;
    rd(A_PND, v);
    chk({tag, " pending"}, v, model_read(A_PND));
    chk({tag, " cascade"}, {31'd0, cascade}, {31'd0, model_cascade()});
  endtask

  task automatic quiesce();
    req = '0;
    wr(A_POL, {14'd0, ALL});
    steps(4);
    wr(A_CLR, {14'd0, ALL});
    chk_reg("quiesce pending R8", A_PND, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd20240613));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_reg("R1 control", A_CTL, 32'h0);
    chk_reg("R1 mask", A_MSK, 32'h0);
    chk_reg("R1 pending", A_PND, 32'h0);
    chk_reg("R1 polarity", A_POL, 32'h0003FFFF);
    chk("R1 cascade", {31'd0, cascade}, 32'h0);

    // R2 decode and widths
    chk_reg("R2 unmapped 0x14", 5'h14, 32'h0);
    chk_reg("R2 misaligned 0x02", 5'h02, 32'h0);
    chk_reg("R2 clear port reads zero", A_CLR, 32'h0);
    wr(A_CTL, 32'hFFFFFFFF);
    chk_reg("R2 control width", A_CTL, 32'hC0000000);
    wr(A_MSK, 32'hFFFFFFFF);
    chk_reg("R2 mask width", A_MSK, 32'h0003FFFF);
    wr(A_POL, 32'hFFFFFFFF);
    chk_reg("R2 polarity width", A_POL, 32'h0003FFFF);
    wr(A_CTL, 32'h0);
    wr(A_MSK, 32'h0);

    // R3 readback
    wr(A_MSK, 32'h0002A5C3);
    chk_reg("R3 mask", A_MSK, 32'h0002A5C3);
    wr(A_CTL, 32'h80000000);
    chk_reg("R3 control", A_CTL, 32'h80000000);
    wr(A_POL, 32'hFFF3FFFF);
    chk_reg("R3 polarity", A_POL, 32'h0003FFFF);
    wr(A_CTL, 32'h0);
    wr(A_MSK, 32'h0);

    // R4 latency in level mode
    req[3] = 1'b1;
    step();
    chk_reg("R4 after 1 edge", A_PND, 32'h0);
    step();
    chk_reg("R4 after 2 edges", A_PND, 32'h0);
    step();
    chk_reg("R4 after 3 edges", A_PND, 32'h8);
    req[3] = 1'b0;
    steps(3);
    wr(A_CLR, 32'h8);
    chk_reg("R8 clear after release", A_PND, 32'h0);

    // R5 active-low source
    wr(A_POL, {14'd0, ALL & ~(18'd1 << 5)});
    step();
    chk_reg("R5 active low with wire low", A_PND, 32'h20);
    req[5] = 1'b1;
    steps(3);
    wr(A_CLR, 32'h20);
    step();
    chk_reg("R5 active low with wire high", A_PND, 32'h0);
    quiesce();

    // R6 level clear while active
    req[7] = 1'b1;
    steps(3);
    wr(A_CLR, 32'h80);
    chk_reg("R6 level bit survives clear", A_PND, 32'h80);
    quiesce();

    // R7 edge mode
    wr(A_CTL, 32'h40000000);
    req[9] = 1'b1;
    steps(3);
    chk_reg("R7 edge captured", A_PND, 32'h200);
    wr(A_CLR, 32'h200);
    chk_reg("R7 cleared while held", A_PND, 32'h0);
    steps(2);
    chk_reg("R7 stays clear while held", A_PND, 32'h0);
    req[9] = 1'b0;
    steps(3);
    req[9] = 1'b1;
    steps(3);
    chk_reg("R7 new edge captured", A_PND, 32'h200);
    quiesce();

    // R8 write-one-to-clear details
    wr(A_CTL, 32'h0);
    req[1:0] = 2'b11;
    steps(3);
    req[1:0] = 2'b00;
    steps(3);
    chk_reg("R8 latched pair", A_PND, 32'h3);
    wr(A_CLR, 32'h0);
    chk_reg("R8 zero write no effect", A_PND, 32'h3);
    wr(A_PND, 32'hFFFFFFFF);
    chk_reg("R8 pending offset write ignored", A_PND, 32'h3);
    wr(A_CLR, 32'h1);
    chk_reg("R8 single bit cleared", A_PND, 32'h2);
    quiesce();

    // R9 capture beats clear on the same edge
    wr(A_CTL, 32'h40000000);
    req[11] = 1'b1;
    steps(2);
    wr(A_CLR, 32'h800);
    chk_reg("R9 set wins over clear", A_PND, 32'h800);

    // R10 cascade gating
    chk("R10 global off", {31'd0, cascade}, 32'h0);
    wr(A_MSK, 32'h800);
    chk("R10 masked in, global off", {31'd0, cascade}, 32'h0);
    wr(A_CTL, 32'hC0000000);
    chk("R10 global on", {31'd0, cascade}, 32'h1);
    wr(A_MSK, 32'h400);
    chk("R10 other bit unmasked", {31'd0, cascade}, 32'h0);
    wr(A_MSK, 32'h800);
    chk("R10 unmasked again", {31'd0, cascade}, 32'h1);
    wr(A_CLR, 32'h800);
    chk("R10 cleared drops", {31'd0, cascade}, 32'h0);

    // R11 masked capture
    req[13] = 1'b1;
    steps(3);
    chk_reg("R11 masked source pending", A_PND, 32'h2000);
    chk("R11 masked source silent", {31'd0, cascade}, 32'h0);
    wr(A_MSK, 32'h2000);
    chk("R11 unmasked source drives", {31'd0, cascade}, 32'h1);
    quiesce();

    // random phase against the reference model (R4 R6 R7 R8 R10)
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) req[$urandom_range(0, N-1)] ^= 1'b1;
      if ($urandom_range(0, 7) == 0) begin
        case ($urandom_range(0, 5))
          0: d = {$urandom_range(0, 3) == 0 ? 1'b0 : 1'b1, 1'($urandom), 30'($urandom)};
          default: d = $urandom;
        endcase
        case ($urandom_range(0, 5))
          0: wr(A_CTL, d);
          1: wr(A_MSK, d);
          2: wr(A_CLR, d);
          3: wr(A_POL, d);
          4: wr(A_PND, d);
          default: wr(5'h1C, d);
        endcase
      end else begin
        step();
      end
      chk_model("R10 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule